// File: doc/BRIEF.md
# Mailbox command request sequencer

This block runs one full command exchange with a service processor over a simple register bus. A host pulses `start` with a four-word request, a mask that picks which request words get written and a mask that picks which reply words get read. The sequencer stamps a fresh 16-bit sequence number into the request header. It confirms that the target is idle and writes the chosen request words. It then rings the target doorbell and polls the reply doorbell at a fixed interval until a reply shows up or a time limit runs out.

Once a reply is flagged, the block reads the chosen reply words and clears the reply flag through an AND alias of the reply doorbell. It then checks the reply header against what was sent. The exchange ends with a one-cycle `done` pulse and a 2-bit result code. The result code, the sequence number used and the reply words stay on the outputs until the next exchange starts.

The bus carries one access per cycle. For a read, `bus_rdata` is valid in the same cycle as the request. All addresses are `BASE` plus a fixed offset. Header word layout, from bit 63 down: 16 bits reserved (request) or primary status (reply), 16 bits control flags or secondary status, 16 bits sequence number, 8 bits command class, 8 bits command.

Top module: `mbox_cmd_seq`

## Requirements
- R1: Each accepted start increments a 16-bit sequence counter that resets to 0, so the first exchange uses 1. The value goes into bits 31:16 of request word 0. All other bits of word 0 are written unchanged, and `seq_id` shows the value used.
- R2: The first bus access of an exchange is a read of offset 0x60. If bit 63 of that read is set, the exchange ends with result 1 (not ready) and performs no bus write.
- R3: Request word i (i = 0..3) is written to offset 0x50+i only when bit i of `req_mask` is set. Selected words are written in ascending address order.
- R4: After the request words, exactly one write of 0x8000_0000_0000_0000 goes to offset 0x62.
- R5: The sequencer reads offset 0x63 and treats bit 63 as reply ready. While no reply is ready it waits `POLL_WAIT` cycles and adds `POLL_WAIT` to an elapsed count before polling again. A poll that finds no reply when the elapsed count is strictly greater than the limit ends the exchange with result 2 (timeout). With no reply ever, this gives floor(limit/`POLL_WAIT`)+2 polls, and no reply read and no acknowledge take place.
- R6: `long_tmo` held high at start selects `LONG_LIMIT`; low selects `SHORT_LIMIT`.
- R7: Reply word i is read from offset 0x54+i only when bit i of `rsp_mask` is set, in ascending order. In `rsp_data`, an unread word 0 is all ones and unread words 1 to 3 are zero. Word i sits in bits 64*i+63 : 64*i.
- R8: After the reply words and before `done`, exactly one write of 0x7FFF_FFFF_FFFF_FFFF goes to offset 0x64.
- R9: The result is 3 (bad reply) if reply word 0 has a nonzero primary status, a nonzero secondary status, or a sequence number different from the one sent. Otherwise the result is 0 (OK).
- R10: A start pulse while `busy` is high is ignored. It does not change the sequence counter or the bus traffic.
- R11: `done` is high for exactly one cycle at the end of an exchange, and `busy` is low in that cycle. `result` holds its value until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an exchange (taken only while idle) |
| req_data | input | 256 | Request words; word i in bits 64*i+63:64*i |
| req_mask | input | 4 | Request words to write |
| rsp_mask | input | 4 | Reply words to read |
| long_tmo | input | 1 | Select the long poll limit |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| result | output | 2 | 0 OK, 1 not ready, 2 timeout, 3 bad reply |
| seq_id | output | 16 | Sequence number of the latest exchange |
| rsp_data | output | 256 | Reply words captured |
| bus_en | output | 1 | Bus access strobe |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid in the cycle of the read |

## Verification
The bench builds the block with `POLL_WAIT` = 4, `SHORT_LIMIT` = 12 and `LONG_LIMIT` = 40. With these values a short timeout lands on the fifth poll and a long one on the twelfth. That makes both sides of each strict-greater-than boundary reachable in a few dozen cycles. Keeping the exchange this short also allows a sweep of all 256 pairs of request and reply masks. The sweep shows the sparse transfer order, the default value of unread reply words, and the OK-versus-bad-reply outcome when the header word is left unread.

// File: rtl/mbox_pkg.sv
// Shared constants and types for the mailbox command sequencer.
// Assumes a 64-bit register bus and four request / four reply words.
package mbox_pkg;
    localparam int WORDS = 4;
    localparam int IDX_W = 2;
    localparam int DW    = 64;
    localparam int SEQ_W = 16;

    localparam logic [7:0] OFF_REQ        = 8'h50;
    localparam logic [7:0] OFF_RSP        = 8'h54;
    localparam logic [7:0] OFF_TGT_DB     = 8'h60;
    localparam logic [7:0] OFF_TGT_DB_OR  = 8'h62;
    localparam logic [7:0] OFF_RPL_DB     = 8'h63;
    localparam logic [7:0] OFF_RPL_DB_AND = 8'h64;

    localparam logic [DW-1:0] RING_VAL = 64'h8000_0000_0000_0000;
    localparam logic [DW-1:0] ACK_VAL  = 64'h7FFF_FFFF_FFFF_FFFF;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NOTRDY  = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_BADRPL  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK, ST_WREQ, ST_RING, ST_POLL, ST_WAIT, ST_RRSP, ST_ACK
    } st_e;
endpackage

// File: rtl/mbox_seq_ctr.sv
// Wrapping sequence counter. Assumes bump is a single-cycle request;
// nxt is the value the next exchange will carry.
module mbox_seq_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] nxt
);
    logic [W-1:0] cur_q;

    // Advance the count once per accepted exchange.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur_q <= '0;
        else if (bump) cur_q <= cur_q + 1'b1;
    end

    assign nxt = cur_q + 1'b1;
endmodule

// File: rtl/mbox_word_pick.sv
// Lowest-set-bit picker over a word-pending mask. Assumes N >= 2.
module mbox_word_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest pending word wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/mbox_poll_timer.sv
// Poll spacing and elapsed-time tracking. arm starts one wait interval and
// credits it to the elapsed count; expired compares the count against the
// limit chosen by long_sel (strictly greater). clear zeroes everything.
module mbox_poll_timer #(
    parameter int              POLL_WAIT   = 1000,
    parameter longint unsigned SHORT_LIMIT = 64'd10_000_000,
    parameter longint unsigned LONG_LIMIT  = 64'd3_000_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic arm,
    input  logic long_sel,
    output logic wait_done,
    output logic expired
);
    localparam int EW = $clog2(LONG_LIMIT + POLL_WAIT + 1) + 1;
    localparam int CW = $clog2(POLL_WAIT + 1);

    logic [EW-1:0] elapsed_q;
    logic [CW-1:0] wcnt_q;
    logic          waiting_q;

    // Interval down-counter and accumulated elapsed time.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            elapsed_q <= '0;
            wcnt_q    <= '0;
            waiting_q <= 1'b0;
        end else if (arm) begin
            elapsed_q <= elapsed_q + EW'(POLL_WAIT);
            wcnt_q    <= CW'(POLL_WAIT - 1);
            waiting_q <= 1'b1;
        end else if (waiting_q) begin
            if (wcnt_q == '0) waiting_q <= 1'b0;
            else              wcnt_q    <= wcnt_q - 1'b1;
        end
    end

    assign wait_done = waiting_q && (wcnt_q == '0);
    assign expired   = elapsed_q > (long_sel ? EW'(LONG_LIMIT) : EW'(SHORT_LIMIT));
endmodule

// File: rtl/mbox_cmd_seq.sv
// Mailbox command sequencer: one full request/reply exchange per start.
// Assumes a single-cycle bus whose read data is valid in the cycle of the
// read, and a single requester (starts are taken only while idle).
module mbox_cmd_seq
    import mbox_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter logic [31:0]     BASE        = 32'h000D_0000,
    parameter int              POLL_WAIT   = 1000,
    parameter longint unsigned SHORT_LIMIT = 64'd10_000_000,
    parameter longint unsigned LONG_LIMIT  = 64'd3_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [255:0]      req_data,
    input  logic [3:0]        req_mask,
    input  logic [3:0]        rsp_mask,
    input  logic              long_tmo,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [15:0]       seq_id,
    output logic [255:0]      rsp_data,
    output logic              bus_en,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic [63:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] B = ADDR_W'(BASE);

    st_e                        state_q;
    logic [WORDS-1:0][DW-1:0]   req_q;
    logic [WORDS-1:0][DW-1:0]   rsp_q;
    logic [WORDS-1:0]           pend_q;
    logic [WORDS-1:0]           rmask_q;
    logic                       long_q;
    logic                       done_q;
    res_e                       res_q;
    logic [SEQ_W-1:0]           seq_q;
    logic [SEQ_W-1:0]           seq_nxt;
    logic [IDX_W-1:0]           pick_idx;
    logic                       pick_any;
    logic                       accept;
    logic                       arm;
    logic                       wait_done;
    logic                       expired;
    logic                       rdy_bit;
    logic                       rsp_bad;

    assign accept  = start && (state_q == ST_IDLE);
    assign rdy_bit = bus_rdata[DW-1];
    assign arm     = (state_q == ST_POLL) && !rdy_bit && !expired;
    assign rsp_bad = (rsp_q[0][63:48] != '0) || (rsp_q[0][47:32] != '0) ||
                     (rsp_q[0][31:16] != seq_q);

    mbox_seq_ctr #(.W(SEQ_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .bump(accept), .nxt(seq_nxt)
    );

    mbox_word_pick #(.N(WORDS), .IW(IDX_W)) u_pick (
        .pend(pend_q), .idx(pick_idx), .any(pick_any)
    );

    mbox_poll_timer #(
        .POLL_WAIT(POLL_WAIT), .SHORT_LIMIT(SHORT_LIMIT), .LONG_LIMIT(LONG_LIMIT)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(accept), .arm(arm),
        .long_sel(long_q), .wait_done(wait_done), .expired(expired)
    );

    // Drive the bus access belonging to the current step.
    always_comb begin
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = B;
        bus_wdata = '0;
        unique case (state_q)
            ST_CHK: begin
                bus_en   = 1'b1;
                bus_addr = B + ADDR_W'(OFF_TGT_DB);
            end
            ST_WREQ: if (pick_any) begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = B + ADDR_W'(OFF_REQ) + ADDR_W'(pick_idx);
                bus_wdata = req_q[pick_idx];
            end
            ST_RING: begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = B + ADDR_W'(OFF_TGT_DB_OR);
                bus_wdata = RING_VAL;
            end
            ST_POLL: begin
                bus_en   = 1'b1;
                bus_addr = B + ADDR_W'(OFF_RPL_DB);
            end
            ST_RRSP: if (pick_any) begin
                bus_en   = 1'b1;
                bus_addr = B + ADDR_W'(OFF_RSP) + ADDR_W'(pick_idx);
            end
            ST_ACK: begin
                bus_en    = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = B + ADDR_W'(OFF_RPL_DB_AND);
                bus_wdata = ACK_VAL;
            end
            default: ;
        endcase
    end

    // Exchange sequencing, word capture and result recording.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            rsp_q   <= '0;
            pend_q  <= '0;
            rmask_q <= '0;
            long_q  <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= RES_OK;
            seq_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    req_q    <= req_data;
                    req_q[0] <= {req_data[63:32], seq_nxt, req_data[15:0]};
                    rsp_q    <= '0;
                    rsp_q[0] <= '1;
                    pend_q   <= req_mask;
                    rmask_q  <= rsp_mask;
                    long_q   <= long_tmo;
                    seq_q    <= seq_nxt;
                    state_q  <= ST_CHK;
                end
                ST_CHK: begin
                    if (rdy_bit) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        res_q   <= RES_NOTRDY;
                    end else begin
                        state_q <= ST_WREQ;
                    end
                end
                ST_WREQ: begin
                    if (pick_any) begin
                        pend_q[pick_idx] <= 1'b0;
                    end else begin
                        pend_q  <= rmask_q;
                        state_q <= ST_RING;
                    end
                end
                ST_RING: state_q <= ST_POLL;
                ST_POLL: begin
                    if (rdy_bit) begin
                        state_q <= ST_RRSP;
                    end else if (expired) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        res_q   <= RES_TIMEOUT;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: if (wait_done) state_q <= ST_POLL;
                ST_RRSP: begin
                    if (pick_any) begin
                        rsp_q[pick_idx]  <= bus_rdata;
                        pend_q[pick_idx] <= 1'b0;
                    end else begin
                        state_q <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    res_q   <= rsp_bad ? RES_BADRPL : RES_OK;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign result   = res_q;
    assign seq_id   = seq_q;
    assign rsp_data = rsp_q;
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
// Protocol checker for mbox_cmd_seq, attached by bind. Assumes the same
// BASE and ADDR_W as the design it watches.
module mbox_cmd_seq_chk
    import mbox_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'h000D_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [1:0]        result,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_wdata
);
    localparam logic [ADDR_W-1:0] B = ADDR_W'(BASE);

    logic              wr_req;
    logic              last_vld_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic              wrote_q;

    assign wr_req = bus_en && bus_we &&
                    (bus_addr >= B + ADDR_W'(OFF_REQ)) &&
                    (bus_addr <  B + ADDR_W'(OFF_REQ) + ADDR_W'(WORDS));

    // Track the last request-word address and any write within an exchange.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && !busy)) begin
            last_vld_q  <= 1'b0;
            last_addr_q <= '0;
            wrote_q     <= 1'b0;
        end else begin
            if (wr_req) begin
                last_vld_q  <= 1'b1;
                last_addr_q <= bus_addr;
            end
            if (bus_en && bus_we) wrote_q <= 1'b1;
        end
    end

    // R3
    req_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && last_vld_q) |-> (bus_addr > last_addr_q));

    // R4
    ring_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == B + ADDR_W'(OFF_TGT_DB_OR)) |-> (bus_wdata == RING_VAL));

    // R8
    ack_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == B + ADDR_W'(OFF_RPL_DB_AND)) |-> (bus_wdata == ACK_VAL));

    // R2
    notrdy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_NOTRDY) |-> !wrote_q);

    // R10
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
    localparam int          CLK_P  = 10;
    localparam int          ADDR_W = 32;
    localparam logic [31:0] BASE   = 32'h000D_0000;
    localparam int          PW     = 4;
    localparam int          SLIM   = 12;
    localparam int          LLIM   = 40;
    localparam int          SHORT_POLLS = SLIM / PW + 2;
    localparam int          LONG_POLLS  = LLIM / PW + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [255:0]      req_data = '0;
    logic [3:0]        req_mask = '0;
    logic [3:0]        rsp_mask = '0;
    logic              long_tmo = 1'b0;
    logic              busy, done;
    logic [1:0]        result;
    logic [15:0]       seq_id;
    logic [255:0]      rsp_data;
    logic              bus_en, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [63:0]       bus_wdata;
    logic [63:0]       bus_rdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Target model state
    logic        t_busy = 1'b0;
    int          t_ready_at = 1;
    int          poll_base = 0;
    int          rd63 = 0;
    logic [15:0] t_prim = '0, t_sec = '0, t_seq = '0;
    logic [63:0] rep [1:3];
    logic [31:0] lg_a [0:63];
    logic [63:0] lg_d [0:63];
    int          lg_n = 0;
    logic [15:0] exp_seq = '0;
    logic [15:0] cur_flags = 16'h0101;

    mbox_cmd_seq #(
        .ADDR_W(ADDR_W), .BASE(BASE), .POLL_WAIT(PW),
        .SHORT_LIMIT(64'(SLIM)), .LONG_LIMIT(64'(LLIM))
    ) u_mbox_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req_data(req_data),
        .req_mask(req_mask), .rsp_mask(rsp_mask), .long_tmo(long_tmo),
        .busy(busy), .done(done), .result(result), .seq_id(seq_id),
        .rsp_data(rsp_data), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_P / 2) clk = ~clk;

    initial begin
        rep[1] = 64'h0123_4567_89AB_CDEF;
        rep[2] = 64'h1357_9BDF_0246_8ACE;
        rep[3] = 64'hFEDC_BA98_7654_3210;
    end

    // Combinational target: doorbells and reply words.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BASE + 32'h60) bus_rdata = t_busy ? 64'h8000_0000_0000_0000 : '0;
        else if (bus_addr == BASE + 32'h63)
            bus_rdata = (t_ready_at != 0 && (rd63 - poll_base + 1) >= t_ready_at)
                        ? 64'h8000_0000_0000_0000 : '0;
        else if (bus_addr == BASE + 32'h54) bus_rdata = {t_prim, t_sec, t_seq, 8'hD1, 8'h01};
        else if (bus_addr == BASE + 32'h55) bus_rdata = rep[1];
        else if (bus_addr == BASE + 32'h56) bus_rdata = rep[2];
        else if (bus_addr == BASE + 32'h57) bus_rdata = rep[3];
    end

    // Bus monitor: log writes and count reply-doorbell polls.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && bus_en && bus_we) begin
            lg_a[lg_n & 63] <= bus_addr;
            lg_d[lg_n & 63] <= bus_wdata;
            lg_n <= lg_n + 1;
        end
        if (rst_n && bus_en && !bus_we && bus_addr == BASE + 32'h63) rd63 <= rd63 + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_req();
        return {64'hDDDD_0003_3333_3333, 64'hCCCC_0002_2222_2222,
                64'd500, {16'h0, cur_flags, 16'h0, 8'hD1, 8'h01}};
    endfunction

    task automatic run(input logic [3:0] rqm, input logic [3:0] rsm, input logic lng,
                       input int rdy_at, input logic tbusy, input logic [15:0] prim,
                       input logic [15:0] sec, input logic bad_seq, input string rtag,
                       input bit poke_busy);
        logic [255:0] rq, exp_rsp;
        logic [1:0]   exp_res;
        logic [31:0]  ea [0:7];
        logic [63:0]  ed [0:7];
        int           en, base, pmax, exp_polls, waited;
        bit           tmo, log_ok;
        rq = mk_req();
        exp_seq = exp_seq + 16'd1;
        pmax = lng ? LONG_POLLS : SHORT_POLLS;
        tmo = (rdy_at == 0 || rdy_at > pmax);
        en = 0;
        exp_rsp = '0;
        exp_rsp[63:0] = '1;
        if (tbusy) begin
            exp_res = 2'd1; exp_polls = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (rqm[i]) begin
                    ea[en] = BASE + 32'h50 + 32'(i);
                    ed[en] = (i == 0) ? {rq[63:32], exp_seq, rq[15:0]} : rq[64*i +: 64];
                    en++;
                end
            end
            ea[en] = BASE + 32'h62; ed[en] = 64'h8000_0000_0000_0000; en++;
            if (tmo) begin
                exp_res = 2'd2; exp_polls = pmax;
            end else begin
                ea[en] = BASE + 32'h64; ed[en] = 64'h7FFF_FFFF_FFFF_FFFF; en++;
                exp_polls = rdy_at;
                for (int i = 0; i < 4; i++) begin
                    if (rsm[i]) exp_rsp[64*i +: 64] = (i == 0) ?
                        {prim, sec, exp_seq ^ {15'd0, bad_seq}, 8'hD1, 8'h01} : rep[i];
                end
                exp_res = (exp_rsp[63:48] != 0 || exp_rsp[47:32] != 0 ||
                           exp_rsp[31:16] != exp_seq) ? 2'd3 : 2'd0;
            end
        end
        // Drive the exchange
        @(negedge clk);
        t_busy = tbusy; t_ready_at = rdy_at; t_prim = prim; t_sec = sec;
        t_seq = exp_seq ^ {15'd0, bad_seq};
        poll_base = rd63; base = lg_n;
        req_data = rq; req_mask = rqm; rsp_mask = rsm; long_tmo = lng;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R10: a second start mid-exchange with different inputs
            @(negedge clk);
            req_mask = 4'hF; rsp_mask = 4'h0; long_tmo = ~lng; req_data = '1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, rtag, "done seen", 256'(done), 256'(1));
        chk(result == exp_res, rtag, "result", 256'(result), 256'(exp_res));
        chk(seq_id == exp_seq, poke_busy ? "R10" : "R1", "seq_id", 256'(seq_id), 256'(exp_seq));
        chk(rsp_data == exp_rsp, "R7", "rsp_data", rsp_data, exp_rsp);
        chk((rd63 - poll_base) == exp_polls, lng ? "R6" : "R5", "poll count",
            256'(rd63 - poll_base), 256'(exp_polls));
        log_ok = (lg_n - base) == en;
        for (int k = 0; k < en && k < 8; k++) begin
            if (lg_a[(base + k) & 63] != ea[k] || lg_d[(base + k) & 63] != ed[k]) log_ok = 0;
        end
        chk(log_ok, "R3 R4 R8 R1", "write sequence", 256'(lg_n - base), 256'(en));
        @(negedge clk);
        chk(!done && !busy && result == exp_res, "R11", "pulse end and hold",
            {done, busy, result}, {2'b00, exp_res});
    endtask

    // Watchdog
    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_en && result == 2'd0 && seq_id == 16'd0, "R11",
            "reset state", {busy, done, bus_en, result, seq_id}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // Full mask sweep; deadman start header
        for (int q = 0; q < 16; q++)
            for (int s = 0; s < 16; s++)
                run(4'(q), 4'(s), 1'b0, 1, 1'b0, 16'h0, 16'h0, 1'b0, "R9", 0);
        // Deadman stop header
        cur_flags = 16'h0102;
        run(4'h1, 4'h1, 1'b0, 2, 1'b0, 16'h0, 16'h0, 1'b0, "R9", 0);
        cur_flags = 16'h0101;
        // R2 target busy
        run(4'h3, 4'h1, 1'b0, 1, 1'b1, 16'h0, 16'h0, 1'b0, "R2", 0);
        // R5 short limit boundary
        run(4'h3, 4'h1, 1'b0, SHORT_POLLS,     1'b0, 16'h0, 16'h0, 1'b0, "R5", 0);
        run(4'h3, 4'h1, 1'b0, SHORT_POLLS + 1, 1'b0, 16'h0, 16'h0, 1'b0, "R5", 0);
        run(4'h1, 4'h1, 1'b0, 0,               1'b0, 16'h0, 16'h0, 1'b0, "R5", 0);
        // R6 long limit boundary
        run(4'h3, 4'h1, 1'b1, LONG_POLLS,      1'b0, 16'h0, 16'h0, 1'b0, "R6", 0);
        run(4'h3, 4'h1, 1'b1, LONG_POLLS + 1,  1'b0, 16'h0, 16'h0, 1'b0, "R6", 0);
        // R9 bad replies
        run(4'h1, 4'h1, 1'b0, 3, 1'b0, 16'h0001, 16'h0, 1'b0, "R9", 0);
        run(4'h1, 4'h3, 1'b0, 3, 1'b0, 16'h0, 16'h0010, 1'b0, "R9", 0);
        run(4'h1, 4'hF, 1'b0, 3, 1'b0, 16'h0, 16'h0, 1'b1, "R9", 0);
        // R10 start while busy
        run(4'h5, 4'h9, 1'b0, 3, 1'b0, 16'h0, 16'h0, 1'b0, "R10", 1);
        run(4'h2, 4'h1, 1'b0, 1, 1'b0, 16'h0, 16'h0, 1'b0, "R10", 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule